// File: doc/BRIEF.md
# Posted-Write Register Bridge

This block carries register writes from a fast bus clock into a slow functional clock domain, such as a 32 kHz timer clock. Ten of its registers live in the slow domain. A write to one of them is captured in a bus-side holding register and handed across with a toggle handshake that uses two-flop synchronizers in both directions. A per-register pending bit stays set until the slow domain has taken the value and its acknowledge has come back. Software can poll all ten pending bits in one status word.

A runtime mode bit selects how the bus sees the crossing. In posted mode, a write finishes in one bus cycle. A second write to a register that is still pending is dropped, and a read of such a register returns an error strobe. In non-posted mode, the bus ready is held low until the write has landed, and a read waits until the register is settled. A few bus-side registers never go pending and always answer at once. The slow-domain side is a plain register bank that stands in for the timer logic.

Top module: `posted_reg_bridge`

## Requirements
- R1: After reset, the pending word at 0x34 reads 0, the interface control word at 0x40 reads 4 (posted-mode bit 2 set), and 0x00 reads the ID_VAL parameter.
- R2: The tracked registers and their pending-word bits are: 0x24→bit0, 0x28→bit1, 0x2C→bit2, 0x30→bit3, 0x38→bit4, 0x48→bit5, 0x4C→bit6, 0x50→bit7, 0x54→bit8, 0x58→bit9. In posted mode, a write to a tracked register whose bit is clear completes with ready in its first cycle, and its bit reads 1 from the next bus cycle.
- R3: A pending bit clears by itself once the value has crossed and been acknowledged. After that, a read of the register returns the written value.
- R4: In posted mode, a write to a tracked register whose pending bit is set completes at once and is discarded. The register later reads the earlier value.
- R5: In posted mode, a read of a tracked register whose pending bit is set completes in one cycle with err_o high and rdata_o zero.
- R6: In non-posted mode (bit 2 of 0x40 clear), a write to a tracked register keeps ready_o low until the value has landed. When the write completes, its pending bit is already clear.
- R7: In non-posted mode, a read of a pending register stalls until the bit clears. It then returns the new value with err_o low.
- R8: The registers at 0x10 and 0x1C and the interface control word at 0x40 are bus-side, never set a pending bit, complete in one cycle and read back what was written.
- R9: Several tracked registers can be pending at the same time. Each bit clears on its own, and each register receives its own value.
- R10: An access to an unmapped word completes in one cycle without error, and a read of it returns 0.
- R11: The pending word is read-only, so a write to 0x34 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| fclk_i | input | 1 | Slow functional clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| sel_i | input | 1 | Access request, held until ready_o |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address of a 32-bit word |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid with ready_o |
| ready_o | output | 1 | Access completes on this bus cycle |
| err_o | output | 1 | Error strobe alongside ready_o |

## Verification
The bench builds the block with its defaults: 32-bit data, an 8-bit address and posted mode out of reset. The functional clock runs seven times slower than the bus clock. This keeps every crossing open for tens of bus cycles, so back-to-back accesses reliably hit a pending register: dropped writes, error reads and several overlapping pending bits all occur. The bench then clears the mode bit to measure the stall lengths in non-posted mode.

// File: rtl/posted_reg_bridge.sv
module posted_reg_bridge #(
  parameter int          DW           = 32,
  parameter int          AW           = 8,
  parameter logic [31:0] ID_VAL       = 32'h5A17_0001,
  parameter bit          RESET_POSTED = 1'b1
) (
  input  logic          clk_i,
  input  logic          fclk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  output logic          err_o
);
  localparam int NP = 10;
  localparam int IW = $clog2(NP);

  logic [NP-1:0] req_q, ack1_q, ack2_q, pend;
  logic [NP-1:0] fs1_q, fs2_q, fs3_q;
  logic [NP-1:0][DW-1:0] shadow_q, bank_q;
  logic [DW-1:0] cfg_q, irqen_q;
  logic          posted_q, wait_q;
  logic          phit, cur_pend, acc;
  logic [IW-1:0] pidx;

  always_comb begin
    phit = 1'b1;
    pidx = '0;
    case (addr_i)
      8'h24: pidx = IW'(0);
      8'h28: pidx = IW'(1);
      8'h2C: pidx = IW'(2);
      8'h30: pidx = IW'(3);
      8'h38: pidx = IW'(4);
      8'h48: pidx = IW'(5);
      8'h4C: pidx = IW'(6);
      8'h50: pidx = IW'(7);
      8'h54: pidx = IW'(8);
      8'h58: pidx = IW'(9);
      default: phit = 1'b0;
    endcase
  end

  assign pend     = req_q ^ ack2_q;
  assign cur_pend = phit & pend[pidx];
  assign acc      = sel_i & wr_i & phit & ~wait_q & ~cur_pend;

  always_comb begin
    if (!sel_i)        ready_o = 1'b0;
    else if (!phit)    ready_o = 1'b1;
    else if (posted_q) ready_o = 1'b1;
    else if (wr_i)     ready_o = wait_q & ~cur_pend;
    else               ready_o = ~cur_pend;
  end

  assign err_o = sel_i & ~wr_i & phit & posted_q & cur_pend;

  always_comb begin
    rdata_o = '0;
    if (phit) begin
      if (!cur_pend) rdata_o = bank_q[pidx];
    end else begin
      case (addr_i)
        8'h00: rdata_o = DW'(ID_VAL);
        8'h10: rdata_o = cfg_q;
        8'h1C: rdata_o = irqen_q;
        8'h34: rdata_o = DW'(pend);
        8'h40: rdata_o = DW'({posted_q, 2'b00});
        default: rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= '0;
      shadow_q <= '0;
      wait_q   <= 1'b0;
      cfg_q    <= '0;
      irqen_q  <= '0;
      posted_q <= RESET_POSTED;
      ack1_q   <= '0;
      ack2_q   <= '0;
    end else begin
      ack1_q <= fs3_q;
      ack2_q <= ack1_q;
      for (int i = 0; i < NP; i++) begin
        if (acc && pidx == IW'(i)) begin
          shadow_q[i] <= wdata_i;
          req_q[i]    <= ~req_q[i];
        end
      end
      if (acc && !posted_q)                wait_q <= 1'b1;
      else if (wait_q && sel_i && ready_o) wait_q <= 1'b0;
      if (sel_i && wr_i && !phit) begin
        case (addr_i)
          8'h10: cfg_q    <= wdata_i;
          8'h1C: irqen_q  <= wdata_i;
          8'h40: posted_q <= wdata_i[2];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge fclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs1_q  <= '0;
      fs2_q  <= '0;
      fs3_q  <= '0;
      bank_q <= '0;
    end else begin
      fs1_q <= req_q;
      fs2_q <= fs1_q;
      fs3_q <= fs2_q;
      for (int i = 0; i < NP; i++)
        if (fs2_q[i] ^ fs3_q[i]) bank_q[i] <= shadow_q[i];
    end
  end
endmodule

module posted_reg_bridge_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       wr_i,
  input logic       ready_o,
  input logic       err_o,
  input logic       posted_q,
  input logic       wait_q,
  input logic       phit,
  input logic       cur_pend,
  input logic [9:0] pend,
  input logic [9:0] req_q
);
  a_r5_err_with_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ready_o && sel_i && !wr_i));
  a_r6_no_err_nonposted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !posted_q |-> !err_o);
  a_r6_stall_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && cur_pend) |-> !ready_o);
  a_r4_no_reissue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend) & (req_q ^ $past(req_q))) == 10'd0);
  a_r2_pend_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && phit && posted_q && !cur_pend) |=> (pend != 10'd0));
endmodule

bind posted_reg_bridge posted_reg_bridge_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i),
  .ready_o(ready_o), .err_o(err_o), .posted_q(posted_q), .wait_q(wait_q),
  .phit(phit), .cur_pend(cur_pend), .pend(pend), .req_q(req_q)
);

// File: tb/posted_reg_bridge_tb_top.sv
module posted_reg_bridge_tb_top;
  localparam logic [31:0] IDV = 32'h5A17_0001;

  logic clk = 0, fclk = 0, rst_n = 0;
  logic sel = 0, wr = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata_o;
  logic ready_o, err_o;

  always #5  clk  = ~clk;
  always #35 fclk = ~fclk;

  posted_reg_bridge dut_i (
    .clk_i(clk), .fclk_i(fclk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .ready_o(ready_o), .err_o(err_o));

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] q_dat[$];
  bit          q_err[$];
  bit          q_chk[$];
  string       q_tag[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (sel && ready_o && !wr && q_dat.size() > 0) begin
      logic [31:0] ed; bit ee, ec; string t;
      ed = q_dat.pop_front(); ee = q_err.pop_front();
      ec = q_chk.pop_front(); t = q_tag.pop_front();
      if (ec) begin
        check(rdata_o === ed, t, rdata_o, ed);
        check(err_o === ee, {t, " err"}, {31'b0, err_o}, {31'b0, ee});
      end
    end
  end

  task automatic xfer(input bit w, input logic [7:0] a, input logic [31:0] d, output int cyc);
    @(negedge clk);
    sel = 1; wr = w; addr = a; wdata = d; cyc = 0;
    #1;
    while (!ready_o) begin @(negedge clk); #1; cyc++; end
    @(posedge clk); #1;
    sel = 0; wr = 0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, output int cyc);
    xfer(1'b1, a, d, cyc);
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [31:0] e, input bit ee, input bit c,
                        input string t, output int cyc);
    q_dat.push_back(e); q_err.push_back(ee); q_chk.push_back(c); q_tag.push_back(t);
    xfer(1'b0, a, 32'h0, cyc);
  endtask

  task automatic settle();
    int c, n;
    n = 0;
    do begin
      rd_reg(8'h34, 0, 0, 0, "poll", c);
      n++;
    end while (rdata_o[9:0] != 0 && n < 200);
  endtask

  initial begin
    int c;
    #3000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_reg(8'h34, 0, 0, 1, "R1 pend", c);
    rd_reg(8'h40, 4, 0, 1, "R1 ifctrl", c);
    rd_reg(8'h00, IDV, 0, 1, "R1 id", c);

    wr_reg(8'h10, 32'hA5A5, c); check(c == 0, "R8 cfg wr cycles", c, 0);
    rd_reg(8'h34, 0, 0, 1, "R8 no pend", c);
    rd_reg(8'h10, 32'hA5A5, 0, 1, "R8 cfg", c);
    wr_reg(8'h1C, 32'h3, c);
    rd_reg(8'h1C, 32'h3, 0, 1, "R8 irqen", c);

    wr_reg(8'h28, 32'h1111, c); check(c == 0, "R2 posted wr cycles", c, 0);
    rd_reg(8'h34, 32'h2, 0, 1, "R2 pend bit1", c);
    wr_reg(8'h28, 32'h2222, c); check(c == 0, "R4 dropped wr cycles", c, 0);
    rd_reg(8'h28, 0, 1, 1, "R5 err read", c); check(c == 0, "R5 cycles", c, 0);
    settle();
    rd_reg(8'h34, 0, 0, 1, "R3 pend clear", c);
    rd_reg(8'h28, 32'h1111, 0, 1, "R3 R4 value", c);

    wr_reg(8'h24, 32'h7, c);
    wr_reg(8'h58, 32'h99, c);
    wr_reg(8'h38, 32'h55, c);
    rd_reg(8'h34, 32'h211, 0, 1, "R9 pend multi", c);
    settle();
    rd_reg(8'h24, 32'h7, 0, 1, "R9 ctrl", c);
    rd_reg(8'h58, 32'h99, 0, 1, "R9 maskcnt", c);
    rd_reg(8'h38, 32'h55, 0, 1, "R9 match", c);

    wr_reg(8'h34, 32'hFFFF, c);
    rd_reg(8'h34, 0, 0, 1, "R11 pend ro", c);

    rd_reg(8'h7C, 0, 0, 1, "R10 unmapped", c); check(c == 0, "R10 cycles", c, 0);
    wr_reg(8'h7C, 32'h1, c); check(c == 0, "R10 wr cycles", c, 0);

    wr_reg(8'h2C, 32'hABCD, c);
    wr_reg(8'h40, 32'h0, c);
    rd_reg(8'h40, 0, 0, 1, "R7 mode off", c);
    rd_reg(8'h2C, 32'hABCD, 0, 1, "R7 stalled read", c);
    check(c > 0, "R7 stall cycles", c, 1);

    wr_reg(8'h50, 32'h1234, c);
    check(c >= 3, "R6 stall cycles", c, 3);
    rd_reg(8'h34, 0, 0, 1, "R6 pend after", c);
    rd_reg(8'h50, 32'h1234, 0, 1, "R6 value", c);
    check(c == 0, "R6 read cycles", c, 0);

    wr_reg(8'h40, 32'h4, c);
    rd_reg(8'h40, 4, 0, 1, "R8 ifctrl back", c);

    repeat (4) @(negedge clk);
    check(q_dat.size() == 0, "scoreboard empty", q_dat.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule